// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns parallel words into frames on a single asynchronous transmit line. It runs from the system clock. Bit timing advances only in cycles where a 16x oversampling tick enable is high. A word enters through a valid/ready handshake. Two separate pulse inputs ask for a filler frame, which holds the line high, or a break frame, which holds the line low. The line rests high whenever no frame is in progress.

Four run-time settings shape each frame: word length (8 or 9 bit positions), stop length (half, one, one and a half or two bit times), parity on or off, and parity sense. When parity is on, it occupies the highest bit position, so the frame keeps its length. Filler and break frames take their length from the same settings. The settings are captured when a frame begins. A busy flag and a one-cycle completion pulse report progress to the surrounding logic.

Top module: `uart_frame_tx`

## Requirements
- R1: During reset and whenever no frame is in progress, `tx` is 1, `busy` is 0 and `done` is 0. After reset `tx_ready` is 1.
- R2: A data frame starts with one position at 0, then sends the word bits with bit 0 first, then the stop period at 1. Every bit position lasts 16 ticks.
- R3: With `cfg_nine`=0 the frame carries 8 bit positions, taken from `tx_data[7:0]`, and `tx_data[8]` is ignored. With `cfg_nine`=1 it carries 9 positions from `tx_data[8:0]`.
- R4: `cfg_stop` sets the stop period at level 1: 2'b00 gives 16 ticks, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 24.
- R5: With `cfg_par_en`=1 the highest bit position carries parity over the lower positions that are sent (7 or 8 bits). `cfg_par_odd`=1 makes the count of ones odd and 0 makes it even. The frame length does not change.
- R6: A filler frame (`idle_req` pulse) keeps `tx` at 1 for exactly as many ticks as a data frame under the current settings.
- R7: A break frame (`brk_req` pulse) holds `tx` at 0 for the length of a data frame, including its stop period. It then holds `tx` at 1 for one more stop period.
- R8: A new frame starts only when `busy` is 0. Pending requests are served with break first, then filler, then data. `tx_ready` is 0 while busy or while a break or filler request is pending.
- R9: Changes to the settings after a frame has been accepted do not affect that frame.
- R10: `busy` is 1 from the cycle after acceptance through the cycle of the last stop tick. In the next cycle `done` is 1 for exactly one cycle and `busy` is 0.
- R11: `tx` changes only in response to a tick. A frame spans the same number of ticks whatever the spacing between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 16x oversampling enable |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Word can be accepted this cycle |
| idle_req | input | 1 | Pulse: queue a filler frame |
| brk_req | input | 1 | Pulse: queue a break frame |
| cfg_nine | input | 1 | 0: 8 bit positions, 1: 9 |
| cfg_stop | input | 2 | Stop length code |
| cfg_par_en | input | 1 | Parity occupies top position |
| cfg_par_odd | input | 1 | 1: odd, 0: even |
| tx | output | 1 | Serial line, registered |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares every tick of every frame with a waveform it computes on its own. A wrong bit order, a missing parity replacement or a mis-decoded stop code therefore shows up as a level wrong at a known tick. It flips every setting just after acceptance, which exposes a design that reads the settings live. It queues break and filler requests together while a word is also waiting, so a wrong priority sends the frames in a different order. One frame runs with ticks three cycles apart, so a design that counts clock cycles instead of ticks stretches or shrinks that frame.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_IDLE = 2'd1,
    K_BRK  = 2'd2
  } frame_kind_t;

  typedef enum logic [1:0] {
    PH_REST = 2'd0,
    PH_BODY = 2'd1,
    PH_STOP = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/uft_arbiter.sv
module uft_arbiter
  import uft_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        brk_req,
  input  logic        idle_req,
  input  logic        data_valid,
  input  logic        busy,
  output logic        start,
  output frame_kind_t kind,
  output logic        data_ready
);
  logic brk_pend, idle_pend;

  always_comb begin
    data_ready = !busy && !brk_pend && !idle_pend;
    start      = !busy && (brk_pend || idle_pend || data_valid);
    if (brk_pend)       kind = K_BRK;
    else if (idle_pend) kind = K_IDLE;
    else                kind = K_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_pend  <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      brk_pend  <= (brk_pend && !(start && kind == K_BRK)) || brk_req;
      idle_pend <= (idle_pend && !(start && kind == K_IDLE)) || idle_req;
    end
  end

  // R8: a pending break is launched at the first free cycle
  p_brk_served_r8: assert property (@(posedge clk) disable iff (rst)
    (brk_pend && !busy && !brk_req) |=> (busy && !brk_pend));
endmodule

// File: rtl/uft_framer.sv
module uft_framer #(
  parameter int DATA_W = 9,
  parameter int PW     = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic [DATA_W:0]   body,
  output logic [PW-1:0]     nbits
);
  always_comb begin
    int  nb;
    logic par;
    nb  = cfg_nine ? DATA_W : DATA_W - 1;
    par = cfg_par_odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < nb - 1) par = par ^ data_i[i];
    body    = '1;
    body[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nb) body[i+1] = (cfg_par_en && i == nb - 1) ? par : data_i[i];
    nbits = PW'(nb);
  end
endmodule

// File: rtl/uft_sequencer.sv
module uft_sequencer
  import uft_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9,
  parameter int PW     = $clog2(DATA_W + 1),
  parameter int TCW    = $clog2(2 * OVS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  frame_kind_t     kind,
  input  logic [DATA_W:0] body,
  input  logic [PW-1:0]   nbits,
  input  logic [1:0]      cfg_stop,
  output logic            tx,
  output logic            busy,
  output logic            done
);
  localparam logic [TCW-1:0] BIT_LAST = TCW'(OVS - 1);

  function automatic logic [TCW-1:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'b00:   return TCW'(OVS);
      2'b01:   return TCW'(OVS / 2);
      2'b10:   return TCW'(2 * OVS);
      default: return TCW'((3 * OVS) / 2);
    endcase
  endfunction

  phase_t          phase;
  logic [DATA_W:0] shreg;
  logic [PW-1:0]   pos_left;
  logic [TCW-1:0]  tcnt, stop_t;
  logic            is_brk;
  logic [DATA_W:0] first_body;

  always_comb begin
    case (kind)
      K_IDLE:  first_body = '1;
      K_BRK:   first_body = '0;
      default: first_body = body;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_REST;
      tx       <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      shreg    <= '1;
      pos_left <= '0;
      tcnt     <= '0;
      stop_t   <= TCW'(OVS);
      is_brk   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_REST: if (start) begin
          shreg    <= first_body;
          tx       <= first_body[0];
          pos_left <= nbits;
          tcnt     <= '0;
          stop_t   <= stop_ticks(cfg_stop);
          is_brk   <= (kind == K_BRK);
          busy     <= 1'b1;
          phase    <= PH_BODY;
        end
        PH_BODY: if (tick) begin
          if (tcnt == BIT_LAST) begin
            tcnt <= '0;
            if (pos_left == '0) begin
              phase <= PH_STOP;
              tx    <= !is_brk;
            end else begin
              shreg    <= {1'b1, shreg[DATA_W:1]};
              tx       <= shreg[1];
              pos_left <= pos_left - 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_STOP, PH_TAIL: if (tick) begin
          if (tcnt == stop_t - 1'b1) begin
            tcnt <= '0;
            tx   <= 1'b1;
            if (phase == PH_STOP && is_brk) begin
              phase <= PH_TAIL;
            end else begin
              phase <= PH_REST;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: phase <= PH_REST;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_line_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(stop_t) && $stable(is_brk)));
  p_tick_only_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(tx));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              idle_req,
  input  logic              brk_req,
  input  logic              cfg_nine,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              tx,
  output logic              busy,
  output logic              done
);
  localparam int PW  = $clog2(DATA_W + 1);
  localparam int TCW = $clog2(2 * OVS + 1);

  logic            start;
  frame_kind_t     kind;
  logic [DATA_W:0] body;
  logic [PW-1:0]   nbits;

  uft_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .brk_req    (brk_req),
    .idle_req   (idle_req),
    .data_valid (tx_valid),
    .busy       (busy),
    .start      (start),
    .kind       (kind),
    .data_ready (tx_ready)
  );

  uft_framer #(.DATA_W(DATA_W), .PW(PW)) u_frm (
    .data_i      (tx_data),
    .cfg_nine    (cfg_nine),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .body        (body),
    .nbits       (nbits)
  );

  uft_sequencer #(.OVS(OVS), .DATA_W(DATA_W), .PW(PW), .TCW(TCW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start    (start),
    .kind     (kind),
    .body     (body),
    .nbits    (nbits),
    .cfg_stop (cfg_stop),
    .tx       (tx),
    .busy     (busy),
    .done     (done)
  );

  // R8: no word is taken while a frame runs
  p_ready_free_r8: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !busy);
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  typedef struct packed {
    logic [8:0] data;
    logic       nine;
    logic [1:0] stop;
    logic       pen;
    logic       odd;
    logic [1:0] kind;  // 0 data, 1 filler, 2 break
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{9'h0A5, 1'b0, 2'b00, 1'b0, 1'b0, 2'd0},
    '{9'h1C3, 1'b1, 2'b00, 1'b0, 1'b0, 2'd0},
    '{9'h1C3, 1'b0, 2'b01, 1'b0, 1'b0, 2'd0},
    '{9'h0B7, 1'b0, 2'b10, 1'b1, 1'b0, 2'd0},
    '{9'h0B7, 1'b0, 2'b11, 1'b1, 1'b1, 2'd0},
    '{9'h155, 1'b1, 2'b10, 1'b1, 1'b1, 2'd0},
    '{9'h000, 1'b1, 2'b11, 1'b1, 1'b0, 2'd0},
    '{9'h000, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1},
    '{9'h000, 1'b1, 2'b11, 1'b0, 1'b0, 2'd1},
    '{9'h000, 1'b0, 2'b01, 1'b0, 1'b0, 2'd2},
    '{9'h1FF, 1'b1, 2'b10, 1'b1, 1'b1, 2'd2},
    '{9'h1FF, 1'b1, 2'b01, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 0, idle_req = 0, brk_req = 0;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic [1:0] cfg_stop = 2'b00;
  logic tx_ready, tx, busy, done;

  int n_chk = 0, n_bad = 0;
  int tick_div = 1, tdc = 0;
  bit drop_valid = 1, scramble = 0, finished = 0;
  logic [8:0] next_data = '0;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .tick(tick), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .idle_req(idle_req), .brk_req(brk_req),
    .cfg_nine(cfg_nine), .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .tx(tx), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tdc >= tick_div - 1) begin tdc = 0; tick = 1'b1; end
    else begin tdc = tdc + 1; tick = 1'b0; end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int stop_len(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 8;
      2'b10: return 32;
      default: return 24;
    endcase
  endfunction

  function automatic int frame_len(input vec_t v);
    int n = v.nine ? 9 : 8;
    int s = stop_len(v.stop);
    return (1 + n) * 16 + s + ((v.kind == 2) ? s : 0);
  endfunction

  function automatic logic exp_level(input vec_t v, input int k);
    int n = v.nine ? 9 : 8;
    int s = stop_len(v.stop);
    int bl = (1 + n) * 16;
    int pos, i;
    logic p;
    if (k < bl) begin
      if (v.kind == 2) return 1'b0;
      if (v.kind == 1) return 1'b1;
      pos = k / 16;
      if (pos == 0) return 1'b0;
      i = pos - 1;
      if (v.pen && i == n - 1) begin
        p = v.odd;
        for (int j = 0; j < n - 1; j++) p = p ^ v.data[j];
        return p;
      end
      return v.data[i];
    end
    if (k < bl + s) return (v.kind == 2) ? 1'b0 : 1'b1;
    return 1'b1;
  endfunction

  task automatic observe(input vec_t v, input string tag);
    int k = 0, bad = 0, total, busy_bad = 0;
    bit first = 1;
    logic e;
    total = frame_len(v);
    while (k < total) begin
      step();
      if (first) begin
        first = 0;
        brk_req = 0; idle_req = 0;
        if (drop_valid) tx_valid = 0; else tx_data = next_data;
        if (scramble) begin  // R9: settings change after acceptance
          cfg_nine = ~cfg_nine; cfg_stop = ~cfg_stop;
          cfg_par_en = ~cfg_par_en; cfg_par_odd = ~cfg_par_odd;
        end
      end
      if (busy !== 1'b1 || tx_ready !== 1'b0) busy_bad++;
      if (tick) begin
        e = exp_level(v, k);
        if (tx !== e) bad++;
        k++;
      end
    end
    check(bad == 0, tag, "tick levels wrong", bad, 0);
    check(busy_bad == 0, "R10 R8", "busy/ready wrong mid-frame", busy_bad, 0);
    step();
    check(done === 1'b1 && busy === 1'b0 && tx === 1'b1, "R10", "done/busy/tx after last tick",
          int'({done, busy, tx}), 3'b101);
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg_nine = v.nine; cfg_stop = v.stop; cfg_par_en = v.pen; cfg_par_odd = v.odd;
  endtask

  task automatic run_frame(input vec_t v, input string tag);
    step();
    apply_cfg(v);
    if (v.kind == 0) begin
      tx_data = v.data; tx_valid = 1;
    end else begin
      if (v.kind == 2) brk_req = 1; else idle_req = 1;
      step();
      brk_req = 0; idle_req = 0;
    end
    observe(v, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    vec_t va, vb, vc, vd;
    step();
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "line state in reset",
          int'({tx, busy, done}), 3'b100);
    repeat (2) step();
    rst = 0;
    step();
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0 && tx_ready === 1'b1, "R1",
          "state after reset", int'({tx, busy, done, tx_ready}), 4'b1001);

    // table walk: R2 R3 R4 R5 R6 R7, settings flipped mid-frame for R9
    scramble = 1;
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].kind == 2) tag = "R7 break";
      else if (VECS[i].kind == 1) tag = "R6 filler";
      else if (VECS[i].pen) tag = "R5 R9 parity";
      else tag = "R2 R3 R4 R9 data";
      run_frame(VECS[i], tag);
    end
    scramble = 0;

    // R8 priority: word, break and filler all asked for at once
    va = '{9'h03C, 1'b0, 2'b00, 1'b0, 1'b0, 2'd0};
    vb = '{9'h000, 1'b0, 2'b00, 1'b0, 1'b0, 2'd2};
    vc = '{9'h000, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1};
    vd = '{9'h05A, 1'b0, 2'b00, 1'b0, 1'b0, 2'd0};
    step();
    apply_cfg(va);
    tx_data = va.data; tx_valid = 1; brk_req = 1; idle_req = 1;
    next_data = vd.data;
    drop_valid = 0;
    observe(va, "R8 word accepted first");
    check(tx_ready === 1'b0, "R8", "ready while requests pending", int'(tx_ready), 0);
    observe(vb, "R8 break served before filler");
    observe(vc, "R8 filler served before word");
    drop_valid = 1;
    observe(vd, "R8 word served last");

    // R11: ticks three cycles apart
    tick_div = 3;
    run_frame('{9'h096, 1'b0, 2'b11, 1'b1, 1'b1, 2'd0}, "R11 sparse ticks");
    run_frame('{9'h000, 1'b0, 2'b01, 1'b0, 1'b0, 2'd2}, "R11 R7 sparse break");
    tick_div = 1;
    step();
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "rest state between frames",
          int'({tx, busy, done}), 3'b100);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule